// File: doc/BRIEF.md
# Segmented Image Uniformity Analyzer

This block watches a raster stream of digitized pixel values and measures how evenly the image is lit. The active picture is cut into a square grid of rectangular segments. While a frame streams in, the block keeps a running sum for each segment. When the last pixel of the frame has arrived, it divides each sum by that segment's pixel count to get the segment mean, and it tracks the largest and the smallest of these means.

From those two extremes it produces three figures at once. The first is the absolute spread (largest mean minus smallest mean), used for dark-field tests. The second is that spread divided by a reference level, as a fixed-point value, used for evenly lit tests. The third is the smallest mean, used for saturation tests. A test sequencer picks whichever figure its current test needs. All three are registered and appear together with a single-cycle done pulse.

The division work after the frame is done by one shared sequential divider. While it runs, the block reports busy and ignores every pixel presented to it.

Top module: `segUniAnalyzer`

## Requirements
- R1: The active area of IMG_W by IMG_H pixels is split into GRID by GRID segments. Column segment c covers IMG_W/GRID pixels, and the last column segment also takes the remainder IMG_W%GRID. Rows are split the same way with IMG_H. A pixel's column index counts from the sof pixel and returns to 0 after each eol pixel. Its row index counts eol pixels since sof.
- R2: A segment's mean is its pixel sum divided by its pixel count, rounded down.
- R3: spreadAbs equals the largest segment mean minus the smallest segment mean.
- R4: spreadRatio equals floor(spread * 2^FRAC_W / refLevel). It has FRAC_W fractional bits, and it is 0 when the spread is 0.
- R5: When refLevel is 0, spreadRatio is all ones and refErr is 1. Otherwise refErr is 0.
- R6: minMean equals the smallest segment mean.
- R7: busy rises in the cycle after the pixel that ends the frame is accepted, and stays high until the cycle in which done is high. While busy is high, pixels are ignored, including ones carrying sof.
- R8: A pixel with sof starts a new frame and discards any partly collected frame. Valid pixels that arrive outside a frame, without sof, are ignored. A frame ends on the eol pixel of its last row.
- R9: done is high for exactly one cycle per completed frame. The result outputs change only in that cycle and hold their values otherwise.
- R10: After reset, busy, done, refErr and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Pixel present this cycle |
| pixSof | input | 1 | Pixel is the first of a frame |
| pixEol | input | 1 | Pixel is the last of its line |
| pixData | input | PIX_W | Unsigned pixel value |
| refLevel | input | PIX_W | Reference level for the spread ratio |
| busy | output | 1 | Means and ratio being computed |
| done | output | 1 | One-cycle pulse when results update |
| spreadAbs | output | PIX_W | Largest minus smallest segment mean |
| spreadRatio | output | PIX_W+FRAC_W | Spread over reference, FRAC_W fractional bits |
| minMean | output | PIX_W | Smallest segment mean |
| refErr | output | 1 | Reference level was zero |

## Verification
Suppose a column or row edge counter steps one pixel early or late. Then pixels near segment borders land in the wrong accumulator. This is visible at done as a shifted mean for the bright segment that sits in the remainder column, and so as a wrong spread and ratio. A stuck frame-tracking flag shows up in one of two ways: a garbage line stream produces an unexpected done pulse, or busy drops before done, on the very first cycle where it happens. Off-by-one errors in the divider or in the per-segment counts show up as floor errors in minMean on gradient frames.

// File: rtl/segUniPkg.sv
package segUniPkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic collect;   // accept pixels into the accumulators
    logic divStart;  // launch one division
    logic useRatio;  // divider operands select the spread ratio
    logic takeMean;  // divider result is a segment mean
    logic publish;   // register results, clear sums
  } segStrobes_t;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_MEAN_GO,
    ST_MEAN_WAIT,
    ST_RATIO_GO,
    ST_RATIO_WAIT,
    ST_PUBLISH
  } segState_t;

endpackage

// File: rtl/segUniDiv.sv
module segUniDiv #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  quo;
  logic [CW-1:0] cnt;
  logic [W:0]    shifted;
  logic [W:0]    diff;

  assign shifted = {rem, quo[W-1]};
  assign diff    = shifted - {1'b0, den};
  assign quot    = quo;

  // restoring division, one quotient bit per cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        quo <= num;
        cnt <= CW'(W);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (!diff[W]) begin
          rem <= diff[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= shifted[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/segUniCtrl.sv
module segUniCtrl
  import segUniPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameEnd,
  input  logic        divDone,
  input  logic        lastSeg,
  input  logic        refZero,
  output segStrobes_t stb,
  output logic        busy
);
  segState_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_COLLECT: begin
        stb.collect = 1'b1;
        if (frameEnd) nextState = ST_MEAN_GO;
      end
      ST_MEAN_GO: begin
        stb.divStart = 1'b1;
        nextState    = ST_MEAN_WAIT;
      end
      ST_MEAN_WAIT: begin
        if (divDone) begin
          stb.takeMean = 1'b1;
          nextState    = lastSeg ? ST_RATIO_GO : ST_MEAN_GO;
        end
      end
      ST_RATIO_GO: begin
        stb.useRatio = 1'b1;
        if (refZero) nextState = ST_PUBLISH;
        else begin
          stb.divStart = 1'b1;
          nextState    = ST_RATIO_WAIT;
        end
      end
      ST_RATIO_WAIT: begin
        stb.useRatio = 1'b1;
        if (divDone) nextState = ST_PUBLISH;
      end
      ST_PUBLISH: begin
        stb.publish = 1'b1;
        nextState   = ST_COLLECT;
      end
      default: nextState = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_COLLECT;
    else       state <= nextState;
  end

  assign busy = (state != ST_COLLECT);
endmodule

// File: rtl/segUniPath.sv
module segUniPath
  import segUniPkg::*;
#(
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 492,
  parameter int GRID   = 10,
  parameter int PIX_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  segStrobes_t             stb,
  input  logic                    pixValid,
  input  logic                    pixSof,
  input  logic                    pixEol,
  input  logic [PIX_W-1:0]        pixData,
  input  logic [PIX_W-1:0]        refLevel,
  output logic                    frameEnd,
  output logic                    divDone,
  output logic                    lastSeg,
  output logic                    refZero,
  output logic                    done,
  output logic [PIX_W-1:0]        spreadAbs,
  output logic [PIX_W+FRAC_W-1:0] spreadRatio,
  output logic [PIX_W-1:0]        minMean,
  output logic                    refErr
);
  localparam int SEG_W    = IMG_W / GRID;
  localparam int SEG_H    = IMG_H / GRID;
  localparam int LAST_W   = SEG_W + IMG_W % GRID;
  localparam int LAST_H   = SEG_H + IMG_H % GRID;
  localparam int NSEG     = GRID * GRID;
  localparam int IDX_W    = $clog2(NSEG);
  localparam int GRID_W   = $clog2(GRID);
  localparam int CNT_W    = $clog2(IMG_W + IMG_H + 1);
  localparam int PIXCNT_W = $clog2(LAST_W * LAST_H + 1);
  localparam int ACC_W    = PIX_W + PIXCNT_W;
  localparam int RATIO_W  = PIX_W + FRAC_W;
  localparam int DIV_W    = (ACC_W > RATIO_W) ? ACC_W : RATIO_W;

  localparam logic [GRID_W-1:0] LAST_SEG   = GRID_W'(GRID - 1);
  localparam logic [CNT_W-1:0]  SEG_W_M1   = CNT_W'(SEG_W - 1);
  localparam logic [CNT_W-1:0]  SEG_H_M1   = CNT_W'(SEG_H - 1);
  localparam logic [CNT_W-1:0]  LAST_H_M1  = CNT_W'(LAST_H - 1);
  localparam logic [DIV_W-1:0]  DEN_FULL   = DIV_W'(SEG_W * SEG_H);
  localparam logic [DIV_W-1:0]  DEN_RCOL   = DIV_W'(LAST_W * SEG_H);
  localparam logic [DIV_W-1:0]  DEN_BROW   = DIV_W'(SEG_W * LAST_H);
  localparam logic [DIV_W-1:0]  DEN_CORNER = DIV_W'(LAST_W * LAST_H);

  // raster position
  logic              inFrame;
  logic [GRID_W-1:0] colSeg, rowSeg, curColSeg, curRowSeg;
  logic [CNT_W-1:0]  colIn, rowIn, curColIn, curRowIn;
  logic              accept;
  logic [IDX_W-1:0]  pixIdx;

  assign curColSeg = pixSof ? '0 : colSeg;
  assign curRowSeg = pixSof ? '0 : rowSeg;
  assign curColIn  = pixSof ? '0 : colIn;
  assign curRowIn  = pixSof ? '0 : rowIn;
  assign accept    = stb.collect && pixValid && (pixSof || inFrame);
  assign pixIdx    = IDX_W'(curRowSeg) * IDX_W'(GRID) + IDX_W'(curColSeg);
  assign frameEnd  = accept && pixEol && (curRowSeg == LAST_SEG) && (curRowIn == LAST_H_M1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      colSeg  <= '0;
      rowSeg  <= '0;
      colIn   <= '0;
      rowIn   <= '0;
    end else if (accept) begin
      inFrame <= !frameEnd;
      if (pixEol) begin
        colSeg <= '0;
        colIn  <= '0;
        if (curRowSeg != LAST_SEG && curRowIn == SEG_H_M1) begin
          rowSeg <= curRowSeg + 1'b1;
          rowIn  <= '0;
        end else begin
          rowSeg <= curRowSeg;
          rowIn  <= curRowIn + 1'b1;
        end
      end else begin
        rowSeg <= curRowSeg;
        rowIn  <= curRowIn;
        if (curColSeg != LAST_SEG && curColIn == SEG_W_M1) begin
          colSeg <= curColSeg + 1'b1;
          colIn  <= '0;
        end else begin
          colSeg <= curColSeg;
          colIn  <= curColIn + 1'b1;
        end
      end
    end
  end

  // per-segment sums
  logic [ACC_W-1:0] acc [NSEG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSEG; i++) acc[i] <= '0;
    end else if (stb.publish) begin
      for (int i = 0; i < NSEG; i++) acc[i] <= '0;
    end else if (accept) begin
      for (int i = 0; i < NSEG; i++) begin
        if (pixIdx == IDX_W'(i))
          acc[i] <= (pixSof ? {ACC_W{1'b0}} : acc[i]) + ACC_W'(pixData);
        else if (pixSof)
          acc[i] <= '0;
      end
    end
  end

  // segment walk for the mean pass
  logic [GRID_W-1:0] segCol, segRow;
  logic [IDX_W-1:0]  segIdxRd;
  logic [DIV_W-1:0]  segDen, divNum, divDen, divQuot;
  logic [PIX_W-1:0]  maxM, minM, meanNow, spreadNow;

  assign segIdxRd  = IDX_W'(segRow) * IDX_W'(GRID) + IDX_W'(segCol);
  assign lastSeg   = (segCol == LAST_SEG) && (segRow == LAST_SEG);
  assign refZero   = (refLevel == '0);
  assign meanNow   = divQuot[PIX_W-1:0];
  assign spreadNow = maxM - minM;

  always_comb begin
    unique case ({segRow == LAST_SEG, segCol == LAST_SEG})
      2'b00:   segDen = DEN_FULL;
      2'b01:   segDen = DEN_RCOL;
      2'b10:   segDen = DEN_BROW;
      default: segDen = DEN_CORNER;
    endcase
  end

  assign divNum = stb.useRatio ? DIV_W'({spreadNow, {FRAC_W{1'b0}}}) : DIV_W'(acc[segIdxRd]);
  assign divDen = stb.useRatio ? DIV_W'(refLevel) : segDen;

  segUniDiv #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .start (stb.divStart),
    .num   (divNum),
    .den   (divDen),
    .done  (divDone),
    .quot  (divQuot)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segCol <= '0;
      segRow <= '0;
      maxM   <= '0;
      minM   <= '0;
    end else if (stb.takeMean) begin
      if (segCol == '0 && segRow == '0) begin
        maxM <= meanNow;
        minM <= meanNow;
      end else begin
        if (meanNow > maxM) maxM <= meanNow;
        if (meanNow < minM) minM <= meanNow;
      end
      if (segCol == LAST_SEG) begin
        segCol <= '0;
        segRow <= (segRow == LAST_SEG) ? '0 : segRow + 1'b1;
      end else begin
        segCol <= segCol + 1'b1;
      end
    end
  end

  // registered results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done        <= 1'b0;
      spreadAbs   <= '0;
      spreadRatio <= '0;
      minMean     <= '0;
      refErr      <= 1'b0;
    end else begin
      done <= stb.publish;
      if (stb.publish) begin
        spreadAbs   <= spreadNow;
        minMean     <= minM;
        refErr      <= refZero;
        spreadRatio <= refZero ? {RATIO_W{1'b1}} : divQuot[RATIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/segUniAnalyzer.sv
module segUniAnalyzer
  import segUniPkg::*;
#(
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 492,
  parameter int GRID   = 10,
  parameter int PIX_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pixValid,
  input  logic                    pixSof,
  input  logic                    pixEol,
  input  logic [PIX_W-1:0]        pixData,
  input  logic [PIX_W-1:0]        refLevel,
  output logic                    busy,
  output logic                    done,
  output logic [PIX_W-1:0]        spreadAbs,
  output logic [PIX_W+FRAC_W-1:0] spreadRatio,
  output logic [PIX_W-1:0]        minMean,
  output logic                    refErr
);
  segStrobes_t stb;
  logic frameEnd, divDone, lastSeg, refZero;

  segUniCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameEnd (frameEnd),
    .divDone  (divDone),
    .lastSeg  (lastSeg),
    .refZero  (refZero),
    .stb      (stb),
    .busy     (busy)
  );

  segUniPath #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .GRID  (GRID),
    .PIX_W (PIX_W),
    .FRAC_W(FRAC_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .pixValid    (pixValid),
    .pixSof      (pixSof),
    .pixEol      (pixEol),
    .pixData     (pixData),
    .refLevel    (refLevel),
    .frameEnd    (frameEnd),
    .divDone     (divDone),
    .lastSeg     (lastSeg),
    .refZero     (refZero),
    .done        (done),
    .spreadAbs   (spreadAbs),
    .spreadRatio (spreadRatio),
    .minMean     (minMean),
    .refErr      (refErr)
  );
endmodule

// File: rtl/segUniChk.sv
module segUniChk #(
  parameter int PIX_W  = 12,
  parameter int FRAC_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    pixValid,
  input logic                    pixSof,
  input logic                    pixEol,
  input logic [PIX_W-1:0]        pixData,
  input logic [PIX_W-1:0]        refLevel,
  input logic                    busy,
  input logic                    done,
  input logic [PIX_W-1:0]        spreadAbs,
  input logic [PIX_W+FRAC_W-1:0] spreadRatio,
  input logic [PIX_W-1:0]        minMean,
  input logic                    refErr
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy || done));

  a_r9_hold_spread: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spreadAbs) |-> done);

  a_r9_hold_min: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(minMean) |-> done);

  a_r9_hold_ratio: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spreadRatio) |-> done);

  a_r5_err_saturates: assert property (@(posedge clk) disable iff (!rstN)
    refErr |-> (spreadRatio == {(PIX_W+FRAC_W){1'b1}}));

  a_r4_zero_spread_ratio: assert property (@(posedge clk) disable iff (!rstN)
    (done && spreadAbs == '0 && !refErr) |-> (spreadRatio == '0));
endmodule

bind segUniAnalyzer segUniChk #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/segUniAnalyzer_bench.sv
module segUniAnalyzer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 43;
  localparam int H  = 32;
  localparam int G  = 10;
  localparam int PW = 12;
  localparam int FW = 8;
  localparam int RW = PW + FW;
  localparam int SW = W / G;
  localparam int SH = H / G;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0, pixSof = 1'b0, pixEol = 1'b0;
  logic [PW-1:0] pixData = '0, refLevel = '0;
  logic busy, done, refErr;
  logic [PW-1:0] spreadAbs, minMean;
  logic [RW-1:0] spreadRatio;

  segUniAnalyzer #(.IMG_W(W), .IMG_H(H), .GRID(G), .PIX_W(PW), .FRAC_W(FW)) u_segUniAnalyzer (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixSof(pixSof), .pixEol(pixEol),
    .pixData(pixData), .refLevel(refLevel), .busy(busy), .done(done),
    .spreadAbs(spreadAbs), .spreadRatio(spreadRatio), .minMean(minMean), .refErr(refErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int expSpread, expRatio, expMin, expErr;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pixVal(input int pat, input int x, input int y);
    case (pat)
      0: return x * 20 + y * 30;
      1: return x * 20 + y * 30 + ((x >= 9 * SW && y >= 6 * SH && y < 7 * SH) ? 2000 : 0);
      2: return 1000;
      default: return (x * 3 + y * 7) % 11;
    endcase
  endfunction

  task automatic computeExp(input int pat, input int refv);
    longint sums[G*G];
    int cnts[G*G];
    int mx, mn, m, cs, rs;
    for (int i = 0; i < G*G; i++) begin sums[i] = 0; cnts[i] = 0; end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        cs = x / SW; if (cs > G - 1) cs = G - 1;
        rs = y / SH; if (rs > G - 1) rs = G - 1;
        sums[rs*G+cs] += pixVal(pat, x, y);
        cnts[rs*G+cs]++;
      end
    mx = 0; mn = 1 << 30;
    for (int i = 0; i < G*G; i++) begin
      m = int'(sums[i] / cnts[i]);
      if (m > mx) mx = m;
      if (m < mn) mn = m;
    end
    expSpread = mx - mn;
    expMin    = mn;
    expErr    = (refv == 0);
    expRatio  = (refv == 0) ? (1 << RW) - 1 : (expSpread * 256) / refv;
  endtask

  task automatic driveFrame(input int pat, input int rows, input bit withSof);
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < W; x++) begin
        if ((x + y) % 7 == 3) begin
          @(negedge clk); pixValid = 1'b0; pixSof = 1'b0; pixEol = 1'b0;
        end
        @(negedge clk);
        pixValid = 1'b1;
        pixSof   = withSof && x == 0 && y == 0;
        pixEol   = (x == W - 1);
        pixData  = PW'(pixVal(pat, x, y));
      end
    @(negedge clk);
    pixValid = 1'b0; pixSof = 1'b0; pixEol = 1'b0;
  endtask

  // busy expected high from here until done; optionally throw junk at the block
  task automatic waitDone(input bit junk);
    int n = 0;
    check(busy === 1'b1, "R7 busy after frame end", busy, 1);
    forever begin
      @(negedge clk);
      if (done === 1'b1) break;
      check(busy === 1'b1, "R7 busy held", busy, 1);
      if (junk) begin
        pixValid = 1'b1; pixSof = (n % 3 == 0); pixEol = (n % 5 == 0); pixData = '1;
      end
      n++;
    end
    check(busy === 1'b0, "R7 busy low at done", busy, 0);
    pixValid = 1'b0; pixSof = 1'b0; pixEol = 1'b0;
  endtask

  task automatic checkResults(input string tag);
    check(spreadAbs == PW'(expSpread), {tag, " R3 spreadAbs"}, spreadAbs, expSpread);
    check(minMean == PW'(expMin), {tag, " R6 minMean"}, minMean, expMin);
    check(spreadRatio == RW'(expRatio), {tag, " R4 spreadRatio"}, spreadRatio, expRatio);
    check(refErr == expErr[0], {tag, " R5 refErr"}, refErr, expErr);
    @(negedge clk);
    check(done === 1'b0, {tag, " R9 done single cycle"}, done, 0);
    repeat (20) @(negedge clk);
    check(spreadAbs == PW'(expSpread) && minMean == PW'(expMin), {tag, " R9 hold"}, spreadAbs, expSpread);
  endtask

  task automatic runFrame(input int pat, input int refv, input bit junk, input string tag);
    refLevel = PW'(refv);
    computeExp(pat, refv);
    driveFrame(pat, H, 1'b1);
    waitDone(junk);
    checkResults(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy === 1'b0 && done === 1'b0, "R10 reset busy/done", {busy, done}, 0);
    check(spreadAbs == '0 && minMean == '0 && spreadRatio == '0 && refErr == 1'b0,
          "R10 reset results", spreadRatio, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2: gradient with a bright segment in the remainder column
    runFrame(1, 700, 1'b0, "bright");
    // uniform field: zero spread
    runFrame(2, 500, 1'b0, "uniform");
    // dark field with zero reference: R5 saturation
    runFrame(3, 0, 1'b0, "dark");

    // R8: partial frame discarded by a new sof
    refLevel = PW'(37);
    computeExp(0, 37);
    driveFrame(2, H / 2, 1'b1);
    driveFrame(0, H, 1'b1);
    waitDone(1'b0);
    checkResults("restart R8");

    // R7: junk during busy, including sof, is ignored
    runFrame(1, 1234, 1'b1, "junk R7");

    // R8: a whole frame without sof must not complete
    driveFrame(0, H, 1'b0);
    begin
      bit sawDone = 0;
      repeat (200) begin
        @(negedge clk);
        if (done === 1'b1 || busy === 1'b1) sawDone = 1;
      end
      check(!sawDone, "R8 no frame without sof", sawDone, 0);
    end
    check(spreadAbs == PW'(expSpread) && minMean == PW'(expMin), "R9 results unchanged", minMean, expMin);

    // gradient alone, small reference: R2 floor and R4 fraction
    runFrame(0, 3, 1'b0, "gradient");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule